// File: doc/BRIEF.md
# DRAM Bus Cycle Sequencer

This block runs single read and write accesses to an asynchronous DRAM hanging off a microcontroller-style external bus. A requester presents an address, a direction, two byte-lane enables and write data while the block is idle. The block then walks a fixed phase sequence, driving the row-address strobe, two column-address strobes, write enable, output enable and a row/column multiplexed address bus, and pulses a completion flag in the last phase.

The row-address strobe is not a dedicated pin. It is one bit of a chip-select vector, and a parameter chooses which area (2 to 5) that is. A 2-bit hold setting inserts zero to three extra cycles after the row strobe falls. During these cycles the row address stays on the bus, which gives slow parts or fast clocks enough row-address hold time before the column address appears.

All strobes, the multiplexed address and the write-data drive come from registers, so the pins change only at clock edges and carry no decode glitches.

Top module: `dram_cycle_seq`

## Requirements
- R1: During and right after reset, every chip-select, both column strobes, write enable and output enable are high (inactive), `done_o` is 0, `idle_o` is 1, `dq_oe_o` is 0, `ma_o` and `rdata_o` are 0.
- R2: A request seen at a clock edge while idle starts an access whose phases follow one per cycle from the next cycle on: precharge, row, the hold cycles, column 1, column 2. `idle_o` is 0 for the whole access and returns to 1 in the cycle after column 2.
- R3: Chip-select bit `RAS_AREA` is low in row, hold, column 1 and column 2, and high in precharge and idle. Every other chip-select bit stays high at all times.
- R4: `ma_o` carries the row address (`req_addr[ADDR_W-1:COL_W]`, zero-extended) in precharge, row and every hold cycle. It carries the column address (`req_addr[COL_W-1:0]`, zero-extended) in column 1 and column 2, and 0 when idle.
- R5: The hold setting `rcd_cfg`, sampled when the request is accepted, inserts exactly that many hold cycles (0, 1, 2 or 3).
- R6: `ucas_n_o` is low in column 1 and column 2 exactly when lane-enable bit 1 (upper byte) was set. `lcas_n_o` does the same for bit 0 (lower byte). Both are high in all other phases.
- R7: On a read (`req_write`=0), `oe_n_o` is low in column 1 and column 2, and `we_n_o` stays high throughout.
- R8: On a write, `we_n_o` is low in column 1 and column 2, and `oe_n_o` stays high throughout. `dq_oe_o` is 1 and `dq_o` equals the accepted write data in those two cycles. Otherwise `dq_oe_o` is 0 and `dq_o` is 0.
- R9: `done_o` is 1 only in column 2. On a read, the value on `dq_i` at the clock edge that ends column 2 appears on `rdata_o` from the next cycle and is held until the next read completes.
- R10: While an access is running, `req_valid`, the request fields and `rcd_cfg` have no effect on it. A request is only taken while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte-pair address; upper bits row, lower COL_W bits column |
| req_be | input | 2 | Lane enables; bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | DATA_W | Write data |
| rcd_cfg | input | 2 | Number of row-hold cycles, 0 to 3 |
| idle_o | output | 1 | Block can take a request |
| done_o | output | 1 | Last cycle of the access |
| rdata_o | output | DATA_W | Captured read data |
| cs_n_o | output | NUM_CS | Chip selects, bit RAS_AREA is the row strobe |
| ucas_n_o | output | 1 | Upper column strobe, active low |
| lcas_n_o | output | 1 | Lower column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| ma_o | output | MA_W | Multiplexed row/column address |
| dq_o | output | DATA_W | Write data to the DRAM |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| dq_i | input | DATA_W | Read data from the DRAM |

## Verification
The bench builds the block with `RAS_AREA` = 5 and `COL_W` = 8 against an 18-bit address. This puts the row strobe on the highest legal area and makes the row (10 bits) wider than the column. The column phase therefore depends on zero-extension of the narrower field, and an off-by-one in choosing the chip-select bit shows up on a neighbour. Every hold setting is run for both directions and for all four lane-enable patterns. Further runs cover back-to-back requests and noise on the request and hold inputs during busy cycles.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_ROW  = 3'd2,
        PH_HOLD = 3'd3,
        PH_COL1 = 3'd4,
        PH_COL2 = 3'd5
    } phase_e;

    localparam int HOLD_W = 2;
    localparam int LANES  = 2;

    function automatic logic ras_phase(input phase_e p);
        return (p == PH_ROW) || (p == PH_HOLD) || (p == PH_COL1) || (p == PH_COL2);
    endfunction

    function automatic logic col_phase(input phase_e p);
        return (p == PH_COL1) || (p == PH_COL2);
    endfunction

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LANES-1:0]     req_be,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [HOLD_W-1:0]    rcd_cfg,
    output phase_e               phase_q_o,
    output phase_e               phase_d_o,
    output logic                 wr_q_o,
    output logic                 wr_d_o,
    output logic [LANES-1:0]     be_d_o,
    output logic [ADDR_W-1:0]    addr_d_o,
    output logic [DATA_W-1:0]    wdata_d_o
);

    typedef struct packed {
        phase_e              phase;
        logic [HOLD_W-1:0]   hold_left;
        logic                wr;
        logic [LANES-1:0]    be;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    ctl_d.phase     = PH_PRE;
                    ctl_d.hold_left = rcd_cfg;
                    ctl_d.wr        = req_write;
                    ctl_d.be        = req_be;
                    ctl_d.addr      = req_addr;
                    ctl_d.wdata     = req_wdata;
                end
            end
            PH_PRE:  ctl_d.phase = PH_ROW;
            PH_ROW:  ctl_d.phase = (ctl_q.hold_left != '0) ? PH_HOLD : PH_COL1;
            PH_HOLD: begin
                ctl_d.hold_left = ctl_q.hold_left - 1'b1;
                ctl_d.phase     = (ctl_q.hold_left == HOLD_W'(1)) ? PH_COL1 : PH_HOLD;
            end
            PH_COL1: ctl_d.phase = PH_COL2;
            PH_COL2: ctl_d.phase = PH_IDLE;
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, hold_left: '0, wr: 1'b0, be: '0, addr: '0, wdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase_q_o = ctl_q.phase;
    assign phase_d_o = ctl_d.phase;
    assign wr_q_o    = ctl_q.wr;
    assign wr_d_o    = ctl_d.wr;
    assign be_d_o    = ctl_d.be;
    assign addr_d_o  = ctl_d.addr;
    assign wdata_d_o = ctl_d.wdata;

    // R10: the captured request stays fixed while the access runs
    p_req_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase != PH_IDLE) |=> ($stable(ctl_q.addr) && $stable(ctl_q.wr) && $stable(ctl_q.be)));

    // R5: a hold run never starts with an empty count
    p_hold_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_HOLD) |-> (ctl_q.hold_left != '0));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int COL_W  = 8,
    parameter int MA_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_d,
    input  logic [ADDR_W-1:0] addr_d,
    output logic [MA_W-1:0]   ma_o
);

    localparam int ROW_W = ADDR_W - COL_W;

    typedef struct packed {
        logic [MA_W-1:0] ma;
    } amux_t;

    amux_t am_d, am_q;

    always_comb begin
        am_d = '0;
        unique case (phase_d)
            PH_PRE, PH_ROW, PH_HOLD: am_d.ma[ROW_W-1:0] = addr_d[ADDR_W-1:COL_W];
            PH_COL1, PH_COL2:        am_d.ma[COL_W-1:0] = addr_d[COL_W-1:0];
            default:                 am_d.ma            = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) am_q <= '0;
        else        am_q <= am_d;
    end

    assign ma_o = am_q.ma;

endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
    import dram_seq_pkg::*;
#(
    parameter int NUM_CS   = 8,
    parameter int RAS_AREA = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_d,
    input  logic              wr_d,
    input  logic [LANES-1:0]  be_d,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              ucas_n_o,
    output logic              lcas_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic              done_o
);

    typedef struct packed {
        logic [NUM_CS-1:0] cs_n;
        logic              ucas_n;
        logic              lcas_n;
        logic              we_n;
        logic              oe_n;
        logic              done;
    } strb_t;

    strb_t st_d, st_q;
    logic  ras_on, cas_on;
    logic [NUM_CS-1:0] cs_pattern;

    assign ras_on = ras_phase(phase_d);
    assign cas_on = col_phase(phase_d);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        if (g == RAS_AREA) begin : g_ras
            assign cs_pattern[g] = ~ras_on;
        end else begin : g_idle
            assign cs_pattern[g] = 1'b1;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.cs_n   = cs_pattern;
        st_d.ucas_n = ~(cas_on & be_d[LANES-1]);
        st_d.lcas_n = ~(cas_on & be_d[0]);
        st_d.we_n   = ~(cas_on &  wr_d);
        st_d.oe_n   = ~(cas_on & ~wr_d);
        st_d.done   = (phase_d == PH_COL2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cs_n: '1, ucas_n: 1'b1, lcas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n_o   = st_q.cs_n;
    assign ucas_n_o = st_q.ucas_n;
    assign lcas_n_o = st_q.lcas_n;
    assign we_n_o   = st_q.we_n;
    assign oe_n_o   = st_q.oe_n;
    assign done_o   = st_q.done;

    // R7 / R8: the two direction strobes are never active together
    p_we_oe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!st_q.we_n && !st_q.oe_n));

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

endmodule

// File: rtl/dram_data_path.sv
module dram_data_path
    import dram_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_q,
    input  phase_e            phase_d,
    input  logic              wr_q,
    input  logic              wr_d,
    input  logic [DATA_W-1:0] wdata_d,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] dq;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
    } dpath_t;

    dpath_t dp_d, dp_q;

    always_comb begin
        dp_d       = dp_q;
        dp_d.dq_oe = wr_d && col_phase(phase_d);
        dp_d.dq    = dp_d.dq_oe ? wdata_d : '0;
        if ((phase_q == PH_COL2) && !wr_q) begin
            dp_d.rdata = dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign dq_o    = dp_q.dq;
    assign dq_oe_o = dp_q.dq_oe;
    assign rdata_o = dp_q.rdata;

    // R8: write data is held steady across both column cycles
    p_wdata_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_q.dq_oe && $past(dp_q.dq_oe)) |-> $stable(dp_q.dq));

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int COL_W    = 9,
    parameter int DATA_W   = 16,
    parameter int NUM_CS   = 8,
    parameter int RAS_AREA = 2,
    localparam int ROW_W   = ADDR_W - COL_W,
    localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        rcd_cfg,
    output logic              idle_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              ucas_n_o,
    output logic              lcas_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic [MA_W-1:0]   ma_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    input  logic [DATA_W-1:0] dq_i
);

    phase_e              phase_q, phase_d;
    logic                wr_q, wr_d;
    logic [LANES-1:0]    be_d;
    logic [ADDR_W-1:0]   addr_d;
    logic [DATA_W-1:0]   wdata_d;

    dram_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .rcd_cfg(rcd_cfg),
        .phase_q_o(phase_q), .phase_d_o(phase_d),
        .wr_q_o(wr_q), .wr_d_o(wr_d), .be_d_o(be_d),
        .addr_d_o(addr_d), .wdata_d_o(wdata_d)
    );

    dram_addr_mux #(.ADDR_W(ADDR_W), .COL_W(COL_W), .MA_W(MA_W)) u_amux (
        .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .addr_d(addr_d), .ma_o(ma_o)
    );

    dram_strobe_gen #(.NUM_CS(NUM_CS), .RAS_AREA(RAS_AREA)) u_strb (
        .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .wr_d(wr_d), .be_d(be_d),
        .cs_n_o(cs_n_o), .ucas_n_o(ucas_n_o), .lcas_n_o(lcas_n_o),
        .we_n_o(we_n_o), .oe_n_o(oe_n_o), .done_o(done_o)
    );

    dram_data_path #(.DATA_W(DATA_W)) u_dpath (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_d(phase_d),
        .wr_q(wr_q), .wr_d(wr_d), .wdata_d(wdata_d), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .rdata_o(rdata_o)
    );

    assign idle_o = (phase_q == PH_IDLE);

    // R3: a column strobe is only active under an active row strobe
    p_cas_under_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ucas_n_o || !lcas_n_o) |-> !cs_n_o[RAS_AREA]);

    // R2: precharge keeps the row strobe inactive
    p_pre_ras_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PRE) |-> cs_n_o[RAS_AREA]);

    // R4: the row address does not move during hold cycles
    p_row_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD) |-> $stable(ma_o));

    // R3: only the selected area ever toggles
    p_single_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_o) <= 1);

endmodule

// File: tb/dram_cycle_seq_test.sv
`timescale 1ns/1ps
module dram_cycle_seq_test;

    localparam int ADDR_W   = 18;
    localparam int COL_W    = 8;
    localparam int DATA_W   = 16;
    localparam int NUM_CS   = 8;
    localparam int RAS_AREA = 5;
    localparam int ROW_W    = ADDR_W - COL_W;
    localparam int MA_W     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_be = '0, rcd_cfg = '0;
    logic [DATA_W-1:0] req_wdata = '0, dq_i = '0;
    logic idle_o, done_o, ucas_n_o, lcas_n_o, we_n_o, oe_n_o, dq_oe_o;
    logic [DATA_W-1:0] rdata_o, dq_o;
    logic [NUM_CS-1:0] cs_n_o;
    logic [MA_W-1:0] ma_o;

    always #2.5 clk = ~clk;

    dram_cycle_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W),
                     .NUM_CS(NUM_CS), .RAS_AREA(RAS_AREA)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .rcd_cfg(rcd_cfg),
        .idle_o(idle_o), .done_o(done_o), .rdata_o(rdata_o), .cs_n_o(cs_n_o),
        .ucas_n_o(ucas_n_o), .lcas_n_o(lcas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
        .ma_o(ma_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
    );

    int checks = 0, errors = 0;
    int cycles = 0;

    // reference model: 0 idle, 1 precharge, 2 row, 3 hold, 4 col1, 5 col2
    int cur = 0;
    int seq_q[$];
    logic m_wr = 1'b0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [1:0] m_be = '0;
    logic [DATA_W-1:0] m_wd = '0, m_rd = '0;
    int m_rcd = 0;
    bit noise = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            cur = 0;
            seq_q.delete();
            m_rd = '0;
        end else begin
            if (cur == 5 && !m_wr) m_rd = dq_i;
            if (cur == 0 && req_valid) begin
                m_wr = req_write; m_addr = req_addr; m_be = req_be;
                m_wd = req_wdata; m_rcd = int'(rcd_cfg);
                seq_q.push_back(2);
                for (int k = 0; k < m_rcd; k++) seq_q.push_back(3);
                seq_q.push_back(4);
                seq_q.push_back(5);
                cur = 1;
            end else if (seq_q.size() > 0) begin
                cur = seq_q.pop_front();
            end else begin
                cur = 0;
            end
        end
    end

    // dq_i wanders every cycle so the capture edge matters
    always @(negedge clk) dq_i <= dq_i * 16'd5 + 16'h3a7;

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(cs_n_o == '1 && ucas_n_o && lcas_n_o && we_n_o && oe_n_o && !done_o && idle_o
                && !dq_oe_o && ma_o == '0 && rdata_o == '0, "R1",
                {cs_n_o, ucas_n_o, lcas_n_o, we_n_o, oe_n_o, done_o, idle_o}, {{NUM_CS{1'b1}}, 6'b111101});
        end else begin
            logic [NUM_CS-1:0] e_cs;
            logic [MA_W-1:0] e_ma;
            bit colp;
            colp = (cur == 4 || cur == 5);
            e_cs = '1;
            e_cs[RAS_AREA] = !(cur >= 2);
            e_ma = '0;
            if (cur >= 1 && cur <= 3) e_ma[ROW_W-1:0] = m_addr[ADDR_W-1:COL_W];
            else if (colp) e_ma[COL_W-1:0] = m_addr[COL_W-1:0];
            chk(idle_o == (cur == 0), (cur == 3) ? "R5" : "R2", idle_o, cur == 0);
            chk(cs_n_o == e_cs, "R3", cs_n_o, e_cs);
            chk(ma_o == e_ma, noise ? "R10" : ((cur == 3) ? "R5" : "R4"), ma_o, e_ma);
            chk(ucas_n_o == !(colp && m_be[1]) && lcas_n_o == !(colp && m_be[0]), "R6",
                {ucas_n_o, lcas_n_o}, {!(colp && m_be[1]), !(colp && m_be[0])});
            if (!m_wr || cur == 0)
                chk(we_n_o && oe_n_o == !(colp && !m_wr), "R7", {we_n_o, oe_n_o}, {1'b1, !(colp && !m_wr)});
            else
                chk(oe_n_o && we_n_o == !colp && dq_oe_o == colp && dq_o == (colp ? m_wd : '0), "R8",
                    {we_n_o, oe_n_o, dq_oe_o, dq_o}, {!colp, 1'b1, colp, colp ? m_wd : 16'h0});
            if (cur == 0 || !m_wr)
                chk(!dq_oe_o && dq_o == '0, "R8", {dq_oe_o, dq_o}, 0);
            chk(done_o == (cur == 5) && rdata_o == m_rd, "R9", {done_o, rdata_o}, {cur == 5, m_rd});
        end
    end

    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [1:0] be,
                          input logic [DATA_W-1:0] wd, input logic [1:0] rcd, input bit nz);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be;
        req_wdata = wd; rcd_cfg = rcd;
        @(negedge clk);
        noise = nz;
        if (nz) begin
            req_write = !wr; req_addr = ~a; req_be = ~be; req_wdata = ~wd; rcd_cfg = ~rcd;
        end else begin
            req_valid = 1'b0;
        end
        while (cur != 0) begin
            @(negedge clk);
            if (nz && cur == 5) req_valid = 1'b0;
        end
        noise = 0;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: every hold count, both directions, all lane patterns
        for (int r = 0; r < 4; r++) begin
            for (int b = 0; b < 4; b++) begin
                access(1'b0, 18'h2A5C3 ^ ADDR_W'(r * 977 + b), 2'(b), 16'h0, 2'(r), 1'b0);
                access(1'b1, 18'h15A3C ^ ADDR_W'(b * 311 + r), 2'(b), 16'hC0DE ^ 16'(r * 16 + b), 2'(r), 1'b0);
            end
        end
        // R10: noise on the request inputs while busy
        access(1'b0, 18'h3FF01, 2'b11, 16'h0, 2'd1, 1'b1);
        access(1'b1, 18'h000FF, 2'b10, 16'hBEEF, 2'd3, 1'b1);
        // R2: back-to-back, request held while the previous one finishes
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h1ABCD; req_be = 2'b11; rcd_cfg = 2'd2;
        repeat (3) @(negedge clk);
        req_write = 1'b1; req_addr = 18'h2DCBA; req_wdata = 16'h5A5A; rcd_cfg = 2'd0;
        while (cur != 5) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (cur != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual %0d expected below 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule